// File: doc/BRIEF.md
# Synthesizer Serial Programming Sequencer

This block programs a direct digital synthesizer over a write-only three-wire serial link: a serial clock that idles high, a data line, and an active-low frame select. The host loads a 28-bit tuning word, a 12-bit phase word and a 14-bit control word through a single-cycle load strobe. Two already-debounced request lines, one to step up and one to step down, move the held tuning word by a programmable step amount. Only the rising edge of each request line counts.

Each accepted change sends the whole programming sequence. The sequence is five 16-bit frames, sent MSB first. The target is held in reset while the frames go out and is released by the last frame. The frequency frames are sent even when only the phase changed. A divider setting chooses the serial clock rate from the system clock. Frame select goes high between frames for one full serial clock period. `busy` covers the whole sequence, and `done` marks its end. A change that arrives while a sequence is on the wire is held pending and served as soon as the link is free.

Top module: `synth_prog_seq`

## Requirements
- R1: While reset is asserted, `fsel_n` is 1, `sclk` is 1, `busy` is 0, `done` is 0 and `tune_word` is 0.
- R2: Each sequence is exactly five frames. Frame 0 is `{2'b00, ctrl}` with control bit 8 forced to 1. Frame 1 is `{2'b01, tune[13:0]}`. Frame 2 is `{2'b01, tune[27:14]}`. Frame 3 is `{2'b11, 2'b00, phase[11:0]}`. Frame 4 is `{2'b00, ctrl}` with control bit 8 forced to 0.
- R3: Every frame carries 16 bits, MSB first, with one falling `sclk` edge per bit, all while `fsel_n` is low. `sclk` is high whenever `fsel_n` is high, and it is high when `fsel_n` falls.
- R4: `sdata` changes only together with a rising `sclk` edge, so it holds its value across each falling edge.
- R5: One half-period H of `sclk` is `div_cfg+1` system clocks. `fsel_n` stays low for 33·H clocks per frame, and it stays high for exactly 2·H clocks between frames.
- R6: After a load strobe is sampled at clock edge E0, `tune_word` takes the new value at E1, and `busy` and frame select go active at E2. `busy` then stays high for exactly 173·H clocks.
- R7: `done` is high for one clock, at the edge where `busy` falls, and once per sequence.
- R8: A rising edge on `inc_req` adds `step_amt` to the tuning word, saturating at 2^28−1, then sends a full sequence, with the same latency as a load.
- R9: A rising edge on `dec_req` subtracts `step_amt`, saturating at 0, then sends a full sequence.
- R10: A change requested while `busy` is high is held. `tune_word` does not move while `busy` is high. The pending change is sent as a complete five-frame sequence after the current one ends.
- R11: Holding a request line high produces one step only. Its falling edge has no effect.
- R12: When several changes are pending together, they are served in the order load, then step up, then step down, with one full sequence each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_cfg | input | 8 | Serial half-period minus one, in system clocks; held stable while busy |
| step_amt | input | 28 | Amount added or subtracted per request |
| tune_in | input | 28 | Tuning word captured on `load` |
| phase_in | input | 12 | Phase word captured on `load` |
| ctrl_in | input | 14 | Control word captured on `load` |
| load | input | 1 | Single-cycle strobe that stages the three words |
| inc_req | input | 1 | Debounced step-up request, edge detected |
| dec_req | input | 1 | Debounced step-down request, edge detected |
| sclk | output | 1 | Serial clock, idles high |
| sdata | output | 1 | Serial data, valid at falling `sclk` |
| fsel_n | output | 1 | Active-low frame select |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock end-of-sequence pulse |
| tune_word | output | 28 | Tuning word currently programmed |

## Verification
Counted from the clock edge that samples a request, the new `tune_word` is due one edge later, and `busy` with the first frame select two edges later. The bench reads both just after those edges. The bench also works as a receiver. It samples every falling `sclk` edge away from the system clock edge, and it counts low-select and gap lengths in clocks. These lengths are checked against 33·H and 2·H, and `busy` against 173·H, for several divider settings. The end of each sequence is taken from the `done` sample itself rather than from a fixed delay. This keeps pending and back-to-back sequences aligned with the checks.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int FRAME_W    = 16;
  localparam int PAYLOAD_W  = FRAME_W - 2;
  localparam int TUNE_W     = 2 * PAYLOAD_W;
  localparam int CTRL_W     = PAYLOAD_W;
  localparam int NUM_FRAMES = 5;
  localparam int FRM_W      = $clog2(NUM_FRAMES);
  localparam int BIT_W      = $clog2(FRAME_W);

  localparam logic [1:0] PFX_CTRL  = 2'b00;
  localparam logic [1:0] PFX_FREQ  = 2'b01;
  localparam logic [1:0] PFX_PHASE = 2'b11;

  typedef enum logic [2:0] {
    SER_IDLE,
    SER_HI,
    SER_LO,
    SER_TAIL,
    SER_GAP
  } ser_state_e;
endpackage

// File: rtl/sps_halfper.sv
module sps_halfper #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == '0);

  always_comb begin
    if (restart || tick) cnt_d = div_cfg;
    else                 cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sps_tuner.sv
module sps_tuner
  import synth_prog_pkg::*;
#(
  parameter int PH_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              load,
  input  logic [TUNE_W-1:0] tune_in,
  input  logic [PH_W-1:0]   phase_in,
  input  logic [CTRL_W-1:0] ctrl_in,
  input  logic [TUNE_W-1:0] step_amt,
  input  logic              inc_req,
  input  logic              dec_req,
  output logic [TUNE_W-1:0] tune_q,
  output logic [PH_W-1:0]   phase_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              start
);
  logic              inc_prev_q, dec_prev_q;
  logic              pend_load_q, pend_inc_q, pend_dec_q;
  logic              pend_load_d, pend_inc_d, pend_dec_d;
  logic [TUNE_W-1:0] stg_tune_q;
  logic [PH_W-1:0]   stg_phase_q;
  logic [CTRL_W-1:0] stg_ctrl_q;
  logic [TUNE_W-1:0] tune_d;
  logic              start_q, start_d;
  logic              inc_rise, dec_rise, can_apply;
  logic              apply_load, apply_inc, apply_dec;
  logic [TUNE_W:0]   sum_ext;
  logic [TUNE_W-1:0] up_val, down_val;

  assign inc_rise = inc_req & ~inc_prev_q;
  assign dec_rise = dec_req & ~dec_prev_q;
  assign can_apply = ~busy & ~start_q;
  assign apply_load = can_apply & pend_load_q;
  assign apply_inc  = can_apply & ~pend_load_q & pend_inc_q;
  assign apply_dec  = can_apply & ~pend_load_q & ~pend_inc_q & pend_dec_q;

  assign sum_ext  = {1'b0, tune_q} + {1'b0, step_amt};
  assign up_val   = sum_ext[TUNE_W] ? '1 : sum_ext[TUNE_W-1:0];
  assign down_val = (step_amt > tune_q) ? '0 : (tune_q - step_amt);

  always_comb begin
    pend_load_d = (pend_load_q & ~apply_load) | load;
    pend_inc_d  = (pend_inc_q & ~apply_inc) | inc_rise;
    pend_dec_d  = (pend_dec_q & ~apply_dec) | dec_rise;
    start_d     = apply_load | apply_inc | apply_dec;
    tune_d      = tune_q;
    if (apply_load)     tune_d = stg_tune_q;
    else if (apply_inc) tune_d = up_val;
    else if (apply_dec) tune_d = down_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_prev_q  <= 1'b0;
      dec_prev_q  <= 1'b0;
      pend_load_q <= 1'b0;
      pend_inc_q  <= 1'b0;
      pend_dec_q  <= 1'b0;
      start_q     <= 1'b0;
      tune_q      <= '0;
    end else begin
      inc_prev_q  <= inc_req;
      dec_prev_q  <= dec_req;
      pend_load_q <= pend_load_d;
      pend_inc_q  <= pend_inc_d;
      pend_dec_q  <= pend_dec_d;
      start_q     <= start_d;
      tune_q      <= tune_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_tune_q  <= '0;
      stg_phase_q <= '0;
      stg_ctrl_q  <= '0;
    end else if (load) begin
      stg_tune_q  <= tune_in;
      stg_phase_q <= phase_in;
      stg_ctrl_q  <= ctrl_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      ctrl_q  <= '0;
    end else if (apply_load) begin
      phase_q <= stg_phase_q;
      ctrl_q  <= stg_ctrl_q;
    end
  end

  assign start = start_q;
endmodule

// File: rtl/sps_frame_mux.sv
module sps_frame_mux
  import synth_prog_pkg::*;
#(
  parameter int PH_W    = 12,
  parameter int RST_BIT = 8
) (
  input  logic [FRM_W-1:0]   idx,
  input  logic [TUNE_W-1:0]  tune,
  input  logic [PH_W-1:0]    phase,
  input  logic [CTRL_W-1:0]  ctrl,
  output logic [FRAME_W-1:0] word
);
  localparam int PAD_W = PAYLOAD_W - PH_W;

  logic [CTRL_W-1:0] ctrl_enter, ctrl_leave;

  always_comb begin
    ctrl_enter = ctrl;
    ctrl_enter[RST_BIT] = 1'b1;
    ctrl_leave = ctrl;
    ctrl_leave[RST_BIT] = 1'b0;
  end

  always_comb begin
    unique case (idx)
      FRM_W'(0): word = {PFX_CTRL, ctrl_enter};
      FRM_W'(1): word = {PFX_FREQ, tune[PAYLOAD_W-1:0]};
      FRM_W'(2): word = {PFX_FREQ, tune[TUNE_W-1:PAYLOAD_W]};
      FRM_W'(3): word = {PFX_PHASE, {PAD_W{1'b0}}, phase};
      default:   word = {PFX_CTRL, ctrl_leave};
    endcase
  end
endmodule

// File: rtl/sps_serializer.sv
module sps_serializer
  import synth_prog_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               tick,
  input  logic [FRAME_W-1:0] frame_word,
  output logic [FRM_W-1:0]   frame_idx,
  output logic               restart,
  output logic               sclk,
  output logic               sdata,
  output logic               fsel_n,
  output logic               busy,
  output logic               done
);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);
  localparam logic [FRM_W-1:0] FRM_LAST = FRM_W'(NUM_FRAMES - 1);

  ser_state_e         state_q, state_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic [FRM_W-1:0]   frm_q, frm_d;
  logic               gap2_q, gap2_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic               done_d, in_frame_d;
  logic               sclk_q, sdata_q, fsel_n_q, busy_q, done_q;

  assign frame_idx = (state_q == SER_IDLE) ? '0 : FRM_W'(frm_q + 1'b1);
  assign restart   = (state_q == SER_IDLE);

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    frm_d   = frm_q;
    gap2_d  = gap2_q;
    sh_d    = sh_q;
    done_d  = 1'b0;
    unique case (state_q)
      SER_IDLE: begin
        if (start) begin
          state_d = SER_HI;
          bit_d   = BIT_LAST;
          frm_d   = '0;
          sh_d    = frame_word;
        end
      end
      SER_HI: begin
        if (tick) state_d = SER_LO;
      end
      SER_LO: begin
        if (tick) begin
          if (bit_q == '0) begin
            state_d = SER_TAIL;
          end else begin
            state_d = SER_HI;
            bit_d   = bit_q - 1'b1;
            sh_d    = {sh_q[FRAME_W-2:0], 1'b0};
          end
        end
      end
      SER_TAIL: begin
        if (tick) begin
          if (frm_q == FRM_LAST) begin
            state_d = SER_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = SER_GAP;
            gap2_d  = 1'b0;
          end
        end
      end
      SER_GAP: begin
        if (tick) begin
          if (!gap2_q) begin
            gap2_d = 1'b1;
          end else begin
            state_d = SER_HI;
            frm_d   = FRM_W'(frm_q + 1'b1);
            bit_d   = BIT_LAST;
            sh_d    = frame_word;
          end
        end
      end
      default: state_d = SER_IDLE;
    endcase
  end

  assign in_frame_d = (state_d == SER_HI) || (state_d == SER_LO) || (state_d == SER_TAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SER_IDLE;
      bit_q    <= '0;
      frm_q    <= '0;
      gap2_q   <= 1'b0;
      sh_q     <= '0;
      sclk_q   <= 1'b1;
      sdata_q  <= 1'b0;
      fsel_n_q <= 1'b1;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      bit_q    <= bit_d;
      frm_q    <= frm_d;
      gap2_q   <= gap2_d;
      sh_q     <= sh_d;
      sclk_q   <= (state_d != SER_LO);
      sdata_q  <= in_frame_d & sh_d[FRAME_W-1];
      fsel_n_q <= ~in_frame_d;
      busy_q   <= (state_d != SER_IDLE);
      done_q   <= done_d;
    end
  end

  assign sclk   = sclk_q;
  assign sdata  = sdata_q;
  assign fsel_n = fsel_n_q;
  assign busy   = busy_q;
  assign done   = done_q;
endmodule

// File: rtl/synth_prog_seq.sv
module synth_prog_seq
  import synth_prog_pkg::*;
#(
  parameter int PH_W    = 12,
  parameter int RST_BIT = 8,
  parameter int DIV_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_cfg,
  input  logic [TUNE_W-1:0] step_amt,
  input  logic [TUNE_W-1:0] tune_in,
  input  logic [PH_W-1:0]   phase_in,
  input  logic [CTRL_W-1:0] ctrl_in,
  input  logic              load,
  input  logic              inc_req,
  input  logic              dec_req,
  output logic              sclk,
  output logic              sdata,
  output logic              fsel_n,
  output logic              busy,
  output logic              done,
  output logic [TUNE_W-1:0] tune_word
);
  logic [TUNE_W-1:0]  tune_q;
  logic [PH_W-1:0]    phase_q;
  logic [CTRL_W-1:0]  ctrl_q;
  logic               start, tick, restart;
  logic [FRM_W-1:0]   frame_idx;
  logic [FRAME_W-1:0] frame_word;

  sps_tuner #(.PH_W(PH_W)) u_tuner (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .load     (load),
    .tune_in  (tune_in),
    .phase_in (phase_in),
    .ctrl_in  (ctrl_in),
    .step_amt (step_amt),
    .inc_req  (inc_req),
    .dec_req  (dec_req),
    .tune_q   (tune_q),
    .phase_q  (phase_q),
    .ctrl_q   (ctrl_q),
    .start    (start)
  );

  sps_frame_mux #(.PH_W(PH_W), .RST_BIT(RST_BIT)) u_mux (
    .idx   (frame_idx),
    .tune  (tune_q),
    .phase (phase_q),
    .ctrl  (ctrl_q),
    .word  (frame_word)
  );

  sps_halfper #(.DIV_W(DIV_W)) u_halfper (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .div_cfg (div_cfg),
    .tick    (tick)
  );

  sps_serializer u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .tick       (tick),
    .frame_word (frame_word),
    .frame_idx  (frame_idx),
    .restart    (restart),
    .sclk       (sclk),
    .sdata      (sdata),
    .fsel_n     (fsel_n),
    .busy       (busy),
    .done       (done)
  );

  assign tune_word = tune_q;
endmodule

// File: rtl/synth_prog_seq_chk.sv
module synth_prog_seq_chk
  import synth_prog_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sclk,
  input logic              sdata,
  input logic              fsel_n,
  input logic              busy,
  input logic              done,
  input logic [TUNE_W-1:0] tune_word
);
  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    fsel_n |-> sclk);  // R3
  AST_SELECT_FALLS_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fsel_n) |-> sclk);  // R3
  AST_DATA_HELD_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $stable(sdata));  // R4
  AST_SELECT_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !fsel_n |-> busy);  // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R7
  AST_DONE_AT_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));  // R7
  AST_TUNE_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(tune_word));  // R10
endmodule

bind synth_prog_seq synth_prog_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sclk      (sclk),
  .sdata     (sdata),
  .fsel_n    (fsel_n),
  .busy      (busy),
  .done      (done),
  .tune_word (tune_word)
);

// File: tb/synth_prog_seq_tb.sv
`timescale 1ns/1ps
module synth_prog_seq_tb;
  localparam logic [27:0] TMAX = 28'hFFF_FFFF;

  logic        clk, rst_n;
  logic [7:0]  div_cfg;
  logic [27:0] step_amt, tune_in;
  logic [11:0] phase_in;
  logic [13:0] ctrl_in;
  logic        load, inc_req, dec_req;
  logic        sclk, sdata, fsel_n, busy, done;
  logic [27:0] tune_word;

  synth_prog_seq u_dut (
    .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .step_amt(step_amt),
    .tune_in(tune_in), .phase_in(phase_in), .ctrl_in(ctrl_in),
    .load(load), .inc_req(inc_req), .dec_req(dec_req),
    .sclk(sclk), .sdata(sdata), .fsel_n(fsel_n), .busy(busy),
    .done(done), .tune_word(tune_word)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  // receiver / monitor state
  logic [15:0] rx_w [0:7];
  int rx_bits [0:7];
  int rx_low [0:7];
  int rx_n, busy_len, done_cnt, setup_err, gap_min, gap_max;
  bit seq_done;
  logic p_sclk, p_fs, p_sd;
  logic [15:0] cur_word;
  int cur_bits, cur_low, gap_cur;

  task automatic clr_mon();
    rx_n = 0; busy_len = 0; done_cnt = 0; setup_err = 0;
    gap_min = 1000000; gap_max = 0; seq_done = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      p_sclk = 1'b1; p_fs = 1'b1; p_sd = 1'b0;
      cur_word = '0; cur_bits = 0; cur_low = 0; gap_cur = 0;
    end else begin
      if (!fsel_n) cur_low++;
      if (!fsel_n && p_sclk && !sclk) begin
        cur_word = {cur_word[14:0], sdata};
        cur_bits++;
        if (sdata !== p_sd) setup_err++;
      end
      if (fsel_n && !p_fs) begin
        if (rx_n < 8) begin
          rx_w[rx_n] = cur_word; rx_bits[rx_n] = cur_bits; rx_low[rx_n] = cur_low;
        end
        rx_n++; cur_bits = 0; cur_low = 0; gap_cur = 0;
      end
      if (!fsel_n && p_fs && gap_cur > 0) begin
        if (gap_cur < gap_min) gap_min = gap_cur;
        if (gap_cur > gap_max) gap_max = gap_cur;
        gap_cur = 0;
      end
      if (fsel_n && busy) gap_cur++;
      if (busy) busy_len++;
      if (done) begin done_cnt++; seq_done = 1'b1; end
      p_sclk = sclk; p_fs = fsel_n; p_sd = sdata;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_frame(input int k, input logic [27:0] t,
                                            input logic [11:0] ph, input logic [13:0] c);
    case (k)
      0: return {2'b00, c | 14'h0100};
      1: return {2'b01, t[13:0]};
      2: return {2'b01, t[27:14]};
      3: return {2'b11, 2'b00, ph};
      default: return {2'b00, c & ~14'h0100};
    endcase
  endfunction

  task automatic wait_seq(input logic [27:0] et, input logic [11:0] ep,
                          input logic [13:0] ec, input int h, input string tag);
    int guard = 0;
    bit bits_ok = 1'b1;
    bit low_ok = 1'b1;
    while (!seq_done && guard < 20000) begin
      @(negedge clk); #1; guard++;
    end
    check(seq_done, tag, "sequence completed", seq_done, 1);
    check(rx_n == 5, "R2", "frame count", rx_n, 5);
    for (int k = 0; k < 5; k++) begin
      logic [15:0] ew;
      ew = exp_frame(k, et, ep, ec);
      check(rx_w[k] === ew, "R2", $sformatf("frame %0d word", k), rx_w[k], ew);
      if (rx_bits[k] != 16) bits_ok = 1'b0;
      if (rx_low[k] != 33 * h) low_ok = 1'b0;
    end
    check(bits_ok, "R3", "16 falling edges per frame", rx_bits[0], 16);
    check(low_ok, "R5", "select low length", rx_low[0], 33 * h);
    check(gap_min == 2 * h && gap_max == 2 * h, "R5", "gap length", gap_min, 2 * h);
    check(setup_err == 0, "R4", "data held across falling edge", setup_err, 0);
    check(busy_len == 173 * h, "R6", "busy length", busy_len, 173 * h);
    check(done_cnt == 1, "R7", "done pulse count", done_cnt, 1);
    check(tune_word === et, tag, "tune_word after sequence", tune_word, et);
    clr_mon();
  endtask

  // kind: 0 load, 1 step up, 2 step down
  task automatic kick(input int kind, input logic [27:0] et, input string tag);
    clr_mon();
    if (kind == 0) load = 1'b1;
    else if (kind == 1) inc_req = 1'b1;
    else dec_req = 1'b1;
    @(posedge clk); #1;
    load = 1'b0; inc_req = 1'b0; dec_req = 1'b0;
    @(posedge clk); #1;
    check(busy == 1'b0, "R6", "busy one edge after sample", busy, 0);
    check(tune_word === et, tag, "tune_word one edge after sample", tune_word, et);
    @(posedge clk); #1;
    check(busy == 1'b1 && fsel_n == 1'b0, "R6", "busy and select two edges after sample",
          {busy, fsel_n}, 2'b10);
  endtask

  initial begin
    rst_n = 1'b0; div_cfg = '0; step_amt = '0; tune_in = '0; phase_in = '0;
    ctrl_in = '0; load = 1'b0; inc_req = 1'b0; dec_req = 1'b0;
    clr_mon();
    repeat (3) @(posedge clk);
    #1;
    check(fsel_n == 1'b1 && sclk == 1'b1, "R1", "select and clock in reset", {fsel_n, sclk}, 2'b11);
    check(busy == 1'b0 && done == 1'b0, "R1", "busy and done in reset", {busy, done}, 2'b00);
    check(tune_word === '0, "R1", "tune_word in reset", tune_word, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    #1;
    check(busy_len == 0, "R1", "no sequence without request", busy_len, 0);

    // sweep: divider settings x word patterns
    for (int d = 0; d < 3; d++) begin
      for (int p = 0; p < 3; p++) begin
        logic [27:0] t;
        logic [11:0] ph;
        logic [13:0] c;
        t  = 28'((32'h00A5_1234 * (p + 1) + 32'h0123_4567 * d) ^ (32'h0F0F_0F0F >> p));
        ph = 12'((12'h5A3 ^ 12'(p * 37 + d * 101)));
        c  = (p == 1) ? 14'h3FFF : 14'(14'h0123 * (p + d + 1));
        @(negedge clk); #1;
        div_cfg = 8'(d); tune_in = t; phase_in = ph; ctrl_in = c;
        kick(0, t, "R6");
        wait_seq(t, ph, c, d + 1, "R6");
      end
    end

    // saturation of stepping
    @(negedge clk); #1;
    div_cfg = 8'd0; step_amt = 28'd3; tune_in = TMAX - 28'd4; phase_in = 12'h0F0; ctrl_in = 14'h0022;
    kick(0, TMAX - 28'd4, "R6");
    wait_seq(TMAX - 28'd4, 12'h0F0, 14'h0022, 1, "R6");
    @(negedge clk); #1;
    kick(1, TMAX - 28'd1, "R8");
    wait_seq(TMAX - 28'd1, 12'h0F0, 14'h0022, 1, "R8");
    @(negedge clk); #1;
    kick(1, TMAX, "R8");
    wait_seq(TMAX, 12'h0F0, 14'h0022, 1, "R8");
    @(negedge clk); #1;
    tune_in = 28'd5; step_amt = 28'd7;
    kick(0, 28'd5, "R6");
    wait_seq(28'd5, 12'h0F0, 14'h0022, 1, "R6");
    @(negedge clk); #1;
    kick(2, 28'd0, "R9");
    wait_seq(28'd0, 12'h0F0, 14'h0022, 1, "R9");
    @(negedge clk); #1;
    tune_in = 28'd9; step_amt = 28'd2;
    kick(0, 28'd9, "R6");
    wait_seq(28'd9, 12'h0F0, 14'h0022, 1, "R6");
    @(negedge clk); #1;
    kick(2, 28'd7, "R9");
    wait_seq(28'd7, 12'h0F0, 14'h0022, 1, "R9");

    // request while busy is held pending
    @(negedge clk); #1;
    div_cfg = 8'd1; step_amt = 28'h100; tune_in = 28'h123_4000; phase_in = 12'h321; ctrl_in = 14'h1005;
    kick(0, 28'h123_4000, "R10");
    repeat (10) @(posedge clk);
    #1;
    inc_req = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    inc_req = 1'b0;
    wait_seq(28'h123_4000, 12'h321, 14'h1005, 2, "R10");
    wait_seq(28'h123_4100, 12'h321, 14'h1005, 2, "R10");

    // held level steps once only
    @(negedge clk); #1;
    clr_mon();
    inc_req = 1'b1;
    wait_seq(28'h123_4200, 12'h321, 14'h1005, 2, "R11");
    repeat (50) @(negedge clk);
    #1;
    check(busy_len == 0 && tune_word === 28'h123_4200, "R11", "held level no repeat",
          tune_word, 28'h123_4200);
    inc_req = 1'b0;
    repeat (20) @(negedge clk);
    #1;
    check(busy_len == 0 && tune_word === 28'h123_4200, "R11", "falling edge ignored",
          tune_word, 28'h123_4200);

    // several pending: load, then up, then down
    @(negedge clk); #1;
    div_cfg = 8'd0; step_amt = 28'h010; tune_in = 28'h055_5000; phase_in = 12'hABC; ctrl_in = 14'h2001;
    kick(0, 28'h055_5000, "R12");
    repeat (6) @(posedge clk);
    #1;
    tune_in = 28'h066_6000; phase_in = 12'h0DE; ctrl_in = 14'h0140;
    load = 1'b1; inc_req = 1'b1; dec_req = 1'b1;
    @(posedge clk); #1;
    load = 1'b0; inc_req = 1'b0; dec_req = 1'b0;
    wait_seq(28'h055_5000, 12'hABC, 14'h2001, 1, "R12");
    wait_seq(28'h066_6000, 12'h0DE, 14'h0140, 1, "R12");
    wait_seq(28'h066_6010, 12'h0DE, 14'h0140, 1, "R12");
    wait_seq(28'h066_6000, 12'h0DE, 14'h0140, 1, "R12");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule